// File: doc/BRIEF.md
# Floppy Controller Status and Host Handshake

This block holds the status byte of a floppy disk controller and drives the two host handshake lines: a data request that asks the host to move one byte through the data register, and an interrupt request that marks the end of a command. A command sequencer outside this block reports events such as a byte ready, command finished, record not found, CRC fault, deleted data mark and write-protect fault. The host side is reduced to three strobes: data register access, status register read and command register write.

The status byte depends on the class of the last loaded command. For positioning commands (Type I), several bits are live inverted copies of the drive's active-low lines. For read and write commands (Type II/III), the low bits carry the request line and a lost-data flag. A byte-time watchdog sets the lost-data flag when a pending request is not serviced in time. The byte time is a parameter in clock cycles for double density. Single density doubles it, and a half-rate clock doubles it again.

All pins are plain level or single-cycle strobe signals. There is no valid/ready stream and no back-pressure. The request line itself is the only flow control toward the host.

Top module: `fdc_status_hs`

## Requirements
- R1: Status bit 7 equals NOT drive-ready OR reset asserted, in every command class.
- R2: With class 0 (positioning) loaded, the live status bits are: bit 6 = NOT write-protect line, bit 2 = NOT track-zero line, bit 1 = NOT index line, bit 5 = head-load AND head-settled. These lines are active low.
- R3: Status bit 0 (busy) goes to 1 on the edge that accepts a command load. It goes to 0 on the edge where a done event arrives while busy. `cmd_go_o` is high for exactly the one cycle after an accepted load.
- R4: With class 1 (read) or class 2/3 (write) loaded, status bit 1 equals `drq_o` and status bit 2 equals `lost_data_o`.
- R5: In a read or write class, a byte event while busy raises `drq_o` on the next edge. A data register access lowers it on the next edge. In class 0, byte events are ignored.
- R6: `intrq_o` rises on the edge that takes a done event while busy. It falls after a status read or a command load.
- R7: A class 1, 2 or 3 load with drive-ready low does not start: busy stays 0, `cmd_go_o` stays 0, and `intrq_o` rises at once.
- R8: If `drq_o` stays high for more than L cycles without a data access, `lost_data_o` becomes 1. L = BYTE_CYC_MFM, doubled when `mfm_i`=0 and doubled again when `half_clk_i`=1. An access within L cycles prevents it. The flag stays set until the next load.
- R9: In class 1, a deleted-mark event sets status bit 5. In write classes, bit 5 is 0 and a write-protect event sets bit 6.
- R10: Not-found and CRC events while busy set status bits 4 and 3. These bits stay set until any command load, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| drv_ready_i | input | 1 | Drive ready, active high |
| drv_wprot_n_i | input | 1 | Write protect line, active low |
| drv_trk0_n_i | input | 1 | Track zero line, active low |
| drv_index_n_i | input | 1 | Index line, active low |
| head_load_i | input | 1 | Head load command level |
| head_settled_i | input | 1 | Head load settle timing done |
| mfm_i | input | 1 | 1 = double density, 0 = single density |
| half_clk_i | input | 1 | 1 = half-rate clock selected |
| cmd_load_i | input | 1 | Host writes the command register |
| cmd_cls_i | input | 2 | Class of the loaded command: 0 positioning, 1 read, 2/3 write |
| ev_byte_i | input | 1 | Sequencer: data register holds a byte (read) or is empty (write) |
| ev_done_i | input | 1 | Sequencer: command finished |
| ev_notfound_i | input | 1 | Sequencer: seek verify failed or record not found |
| ev_crc_i | input | 1 | Sequencer: CRC fault |
| ev_deleted_i | input | 1 | Sequencer: deleted data mark seen |
| ev_wprot_i | input | 1 | Sequencer: write refused by protect |
| host_data_acc_i | input | 1 | Host reads or writes the data register |
| host_stat_rd_i | input | 1 | Host reads the status register |
| status_o | output | 8 | Status byte |
| drq_o | output | 1 | Data request to host |
| intrq_o | output | 1 | Interrupt request to host |
| lost_data_o | output | 1 | Host missed a byte |
| cmd_go_o | output | 1 | Start pulse to the sequencer |

## Verification
The properties assume the sequencer raises done, byte and error events only while a command is busy. They also assume all strobes are single-cycle pulses that never arrive during reset. The bench drives every strobe for exactly one cycle after an idle gap and pulses events only between an accepted load and its done event. The drive lines and density selects are randomized freely. Lost-data timing is checked with random service delays that land just inside and just beyond the byte window for every density and clock combination.

// File: rtl/fdc_stat_pkg.sv
package fdc_stat_pkg;
  typedef enum logic [1:0] {
    CLS_POS  = 2'd0,
    CLS_RD   = 2'd1,
    CLS_WR   = 2'd2,
    CLS_WRT  = 2'd3
  } cls_e;

  function automatic logic is_xfer(input cls_e c);
    return c != CLS_POS;
  endfunction

  function automatic logic is_write(input cls_e c);
    return c[1];
  endfunction
endpackage

// File: rtl/fdc_svc_timer.sv
module fdc_svc_timer #(
  parameter int BYTE_CYC_MFM = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  input  logic mfm_i,
  input  logic half_clk_i,
  output logic expire_o
);
  localparam int MAXC = BYTE_CYC_MFM * 4;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic [1:0]    shf;

  always_comb begin
    shf = {1'b0, ~mfm_i} + {1'b0, half_clk_i};
    lim = CW'(BYTE_CYC_MFM) << shf;
  end

  assign expire_o = run_i && !restart_i && (cnt_q == lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (restart_i || !run_i)
      cnt_q <= '0;
    else if (cnt_q != lim - CW'(1))
      cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/fdc_hs_ctl.sv
module fdc_hs_ctl
  import fdc_stat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_load_i,
  input  cls_e cmd_cls_i,
  input  logic ready_i,
  input  logic ev_byte_i,
  input  logic ev_done_i,
  input  logic data_acc_i,
  input  logic stat_rd_i,
  input  logic expire_i,
  output cls_e cls_o,
  output logic busy_o,
  output logic drq_o,
  output logic intrq_o,
  output logic lost_o,
  output logic go_o,
  output logic byte_ok_o
);
  logic accept;

  assign accept    = cmd_load_i && (!is_xfer(cmd_cls_i) || ready_i);
  assign byte_ok_o = ev_byte_i && busy_o && is_xfer(cls_o) && !cmd_load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_o   <= CLS_POS;
      busy_o  <= 1'b0;
      drq_o   <= 1'b0;
      intrq_o <= 1'b0;
      lost_o  <= 1'b0;
      go_o    <= 1'b0;
    end else if (cmd_load_i) begin
      cls_o   <= cmd_cls_i;
      busy_o  <= accept;
      go_o    <= accept;
      drq_o   <= 1'b0;
      lost_o  <= 1'b0;
      intrq_o <= !accept;
    end else begin
      go_o <= 1'b0;
      if (busy_o && ev_done_i) begin
        busy_o  <= 1'b0;
        intrq_o <= 1'b1;
        drq_o   <= 1'b0;
      end else begin
        if (stat_rd_i)
          intrq_o <= 1'b0;
        if (byte_ok_o)
          drq_o <= 1'b1;
        else if (data_acc_i)
          drq_o <= 1'b0;
      end
      if (expire_i && drq_o && !data_acc_i)
        lost_o <= 1'b1;
    end
  end
endmodule

// File: rtl/fdc_err_flags.sv
module fdc_err_flags
  import fdc_stat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic busy_i,
  input  cls_e cls_i,
  input  logic ev_notfound_i,
  input  logic ev_crc_i,
  input  logic ev_deleted_i,
  input  logic ev_wprot_i,
  output logic notfound_o,
  output logic crc_o,
  output logic deleted_o,
  output logic wperr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notfound_o <= 1'b0;
      crc_o      <= 1'b0;
      deleted_o  <= 1'b0;
      wperr_o    <= 1'b0;
    end else if (clr_i) begin
      notfound_o <= 1'b0;
      crc_o      <= 1'b0;
      deleted_o  <= 1'b0;
      wperr_o    <= 1'b0;
    end else if (busy_i) begin
      if (ev_notfound_i) notfound_o <= 1'b1;
      if (ev_crc_i)      crc_o      <= 1'b1;
      if (ev_deleted_i && cls_i == CLS_RD)   deleted_o <= 1'b1;
      if (ev_wprot_i && is_write(cls_i))     wperr_o   <= 1'b1;
    end
  end
endmodule

// File: rtl/fdc_stat_mux.sv
module fdc_stat_mux
  import fdc_stat_pkg::*;
(
  input  cls_e       cls_i,
  input  logic       not_ready_i,
  input  logic       wprot_n_i,
  input  logic       trk0_n_i,
  input  logic       index_n_i,
  input  logic       head_on_i,
  input  logic       busy_i,
  input  logic       drq_i,
  input  logic       lost_i,
  input  logic       notfound_i,
  input  logic       crc_i,
  input  logic       deleted_i,
  input  logic       wperr_i,
  output logic [7:0] status_o
);
  always_comb begin
    status_o[7] = not_ready_i;
    status_o[4] = notfound_i;
    status_o[3] = crc_i;
    status_o[0] = busy_i;
    if (!is_xfer(cls_i)) begin
      status_o[6] = ~wprot_n_i;
      status_o[5] = head_on_i;
      status_o[2] = ~trk0_n_i;
      status_o[1] = ~index_n_i;
    end else begin
      status_o[6] = is_write(cls_i) ? wperr_i : 1'b0;
      status_o[5] = is_write(cls_i) ? 1'b0 : deleted_i;
      status_o[2] = lost_i;
      status_o[1] = drq_i;
    end
  end
endmodule

// File: rtl/fdc_status_hs.sv
module fdc_status_hs
  import fdc_stat_pkg::*;
#(
  parameter int BYTE_CYC_MFM = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       drv_ready_i,
  input  logic       drv_wprot_n_i,
  input  logic       drv_trk0_n_i,
  input  logic       drv_index_n_i,
  input  logic       head_load_i,
  input  logic       head_settled_i,
  input  logic       mfm_i,
  input  logic       half_clk_i,
  input  logic       cmd_load_i,
  input  logic [1:0] cmd_cls_i,
  input  logic       ev_byte_i,
  input  logic       ev_done_i,
  input  logic       ev_notfound_i,
  input  logic       ev_crc_i,
  input  logic       ev_deleted_i,
  input  logic       ev_wprot_i,
  input  logic       host_data_acc_i,
  input  logic       host_stat_rd_i,
  output logic [7:0] status_o,
  output logic       drq_o,
  output logic       intrq_o,
  output logic       lost_data_o,
  output logic       cmd_go_o
);
  cls_e cls_q;
  logic busy, expire, byte_ok;
  logic nf, crc, del, wperr;

  fdc_hs_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_load_i (cmd_load_i),
    .cmd_cls_i  (cls_e'(cmd_cls_i)),
    .ready_i    (drv_ready_i),
    .ev_byte_i  (ev_byte_i),
    .ev_done_i  (ev_done_i),
    .data_acc_i (host_data_acc_i),
    .stat_rd_i  (host_stat_rd_i),
    .expire_i   (expire),
    .cls_o      (cls_q),
    .busy_o     (busy),
    .drq_o      (drq_o),
    .intrq_o    (intrq_o),
    .lost_o     (lost_data_o),
    .go_o       (cmd_go_o),
    .byte_ok_o  (byte_ok)
  );

  fdc_svc_timer #(.BYTE_CYC_MFM(BYTE_CYC_MFM)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (drq_o),
    .restart_i  (byte_ok),
    .mfm_i      (mfm_i),
    .half_clk_i (half_clk_i),
    .expire_o   (expire)
  );

  fdc_err_flags u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr_i         (cmd_load_i),
    .busy_i        (busy),
    .cls_i         (cls_q),
    .ev_notfound_i (ev_notfound_i),
    .ev_crc_i      (ev_crc_i),
    .ev_deleted_i  (ev_deleted_i),
    .ev_wprot_i    (ev_wprot_i),
    .notfound_o    (nf),
    .crc_o         (crc),
    .deleted_o     (del),
    .wperr_o       (wperr)
  );

  fdc_stat_mux u_mux (
    .cls_i       (cls_q),
    .not_ready_i (~drv_ready_i | ~rst_n),
    .wprot_n_i   (drv_wprot_n_i),
    .trk0_n_i    (drv_trk0_n_i),
    .index_n_i   (drv_index_n_i),
    .head_on_i   (head_load_i & head_settled_i),
    .busy_i      (busy),
    .drq_i       (drq_o),
    .lost_i      (lost_data_o),
    .notfound_i  (nf),
    .crc_i       (crc),
    .deleted_i   (del),
    .wperr_i     (wperr),
    .status_o    (status_o)
  );
endmodule

// File: rtl/fdc_status_hs_chk.sv
module fdc_status_hs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       drv_ready_i,
  input logic       cmd_load_i,
  input logic [1:0] cmd_cls_i,
  input logic       ev_byte_i,
  input logic       ev_done_i,
  input logic       host_data_acc_i,
  input logic       host_stat_rd_i,
  input logic [1:0] cls,
  input logic [7:0] status_o,
  input logic       drq_o,
  input logic       intrq_o,
  input logic       lost_data_o,
  input logic       cmd_go_o
);
  p_go_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go_o |-> $past(cmd_load_i));

  p_busy_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[0]) |-> $past(cmd_load_i));

  p_xfer_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cls != 2'd0) |-> (status_o[1] == drq_o && status_o[2] == lost_data_o));

  p_drq_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drq_o && host_data_acc_i && !ev_byte_i && !cmd_load_i |=> !drq_o);

  p_intrq_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] && ev_done_i && !cmd_load_i |=> intrq_o && !status_o[0]);

  p_intrq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_stat_rd_i && !cmd_load_i && !(status_o[0] && ev_done_i) |=> !intrq_o);

  p_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load_i && cmd_cls_i != 2'd0 && !drv_ready_i |=> !status_o[0] && !cmd_go_o && intrq_o);

  p_lost_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lost_data_o && !cmd_load_i |=> lost_data_o);

  always_comb begin
    if (!rst_n) p_reset_notready_r1: assert (status_o[7]);
  end
endmodule

bind fdc_status_hs fdc_status_hs_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .drv_ready_i     (drv_ready_i),
  .cmd_load_i      (cmd_load_i),
  .cmd_cls_i       (cmd_cls_i),
  .ev_byte_i       (ev_byte_i),
  .ev_done_i       (ev_done_i),
  .host_data_acc_i (host_data_acc_i),
  .host_stat_rd_i  (host_stat_rd_i),
  .cls             (cls_q),
  .status_o        (status_o),
  .drq_o           (drq_o),
  .intrq_o         (intrq_o),
  .lost_data_o     (lost_data_o),
  .cmd_go_o        (cmd_go_o)
);

// File: tb/fdc_status_hs_bench.sv
module fdc_status_hs_bench;
  localparam int BC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rdy = 1'b1, wp_n = 1'b1, t0_n = 1'b1, ix_n = 1'b1, hl = 1'b0, hs = 1'b0;
  logic mfm = 1'b1, half = 1'b0;
  logic load = 1'b0;
  logic [1:0] cls = 2'd0;
  logic eb = 1'b0, ed = 1'b0, enf = 1'b0, ecrc = 1'b0, edel = 1'b0, ewp = 1'b0;
  logic dacc = 1'b0, srd = 1'b0;
  logic [7:0] st;
  logic drq, intrq, lost, go;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fdc_status_hs #(.BYTE_CYC_MFM(BC)) u_fdc_status_hs (
    .clk(clk), .rst_n(rst_n), .drv_ready_i(rdy), .drv_wprot_n_i(wp_n),
    .drv_trk0_n_i(t0_n), .drv_index_n_i(ix_n), .head_load_i(hl),
    .head_settled_i(hs), .mfm_i(mfm), .half_clk_i(half), .cmd_load_i(load),
    .cmd_cls_i(cls), .ev_byte_i(eb), .ev_done_i(ed), .ev_notfound_i(enf),
    .ev_crc_i(ecrc), .ev_deleted_i(edel), .ev_wprot_i(ewp),
    .host_data_acc_i(dacc), .host_stat_rd_i(srd), .status_o(st),
    .drq_o(drq), .intrq_o(intrq), .lost_data_o(lost), .cmd_go_o(go)
  );

  function automatic logic [7:0] exp_pos(input logic r, input logic nf, input logic cr,
                                         input logic b);
    return {~r, ~wp_n, hl & hs, nf, cr, ~t0_n, ~ix_n, b};
  endfunction

  function automatic int lim_of(input logic m, input logic h);
    return BC << ((m ? 0 : 1) + (h ? 1 : 0));
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    load = 1'b0; eb = 1'b0; ed = 1'b0; enf = 1'b0; ecrc = 1'b0;
    edel = 1'b0; ewp = 1'b0; dacc = 1'b0; srd = 1'b0;
  endtask

  task automatic do_load(input logic [1:0] c);
    load = 1'b1; cls = c;
    tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 reset not-ready", {7'd0, st[7]}, 8'd1);
    check("R5 R6 reset handshake", {6'd0, drq, intrq}, 8'd0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 40; i++) begin
      {rdy, wp_n, t0_n, ix_n, hl, hs} = 6'($urandom);
      #1;
      check("R1 R2 live positioning bits", st, exp_pos(rdy, 1'b0, 1'b0, 1'b0));
    end

    rdy = 1'b0;
    do_load(2'd0);
    check("R3 busy after positioning load", st, exp_pos(rdy, 1'b0, 1'b0, 1'b1));
    check("R3 go pulse", {7'd0, go}, 8'd1);
    eb = 1'b1; enf = 1'b1; ecrc = 1'b1;
    tick();
    check("R3 go single cycle", {7'd0, go}, 8'd0);
    check("R5 byte ignored in positioning", {7'd0, drq}, 8'd0);
    check("R10 error bits set", st, exp_pos(rdy, 1'b1, 1'b1, 1'b1));
    ed = 1'b1;
    tick();
    check("R6 intrq on done", {6'd0, intrq, st[0]}, 8'b10);
    srd = 1'b1;
    tick();
    check("R6 status read clears intrq", {7'd0, intrq}, 8'd0);
    check("R10 errors sticky after done", st[4:3], 2'b11);
    do_load(2'd0);
    check("R10 load clears errors", st[4:3], 2'b00);
    ed = 1'b1;
    tick();

    rdy = 1'b0;
    do_load(2'd1);
    check("R7 not ready read rejected", {5'd0, go, intrq, st[0]}, 8'b010);
    check("R1 not ready read class", {7'd0, st[7]}, 8'd1);
    rdy = 1'b1;
    do_load(2'd1);
    check("R6 load clears intrq R3 busy", {6'd0, intrq, st[0]}, 8'b01);
    edel = 1'b1;
    tick();
    check("R9 deleted mark bit5", {7'd0, st[5]}, 8'd1);
    eb = 1'b1;
    tick();
    check("R5 drq rise R4 status bit1", {6'd0, drq, st[1]}, 8'b11);
    dacc = 1'b1;
    tick();
    check("R5 drq fall on access", {6'd0, drq, st[1]}, 8'b00);

    for (int i = 0; i < 16; i++) begin
      int j, l;
      logic el;
      mfm = 1'($urandom); half = 1'($urandom);
      l = lim_of(mfm, half);
      j = (i < 4) ? ((i % 2 == 0) ? l : l + 1) : 1 + int'($urandom_range(0, l + 2));
      el = (j > l);
      do_load(2'(1 + (i % 3)));
      check("R8 load clears lost", {7'd0, lost}, 8'd0);
      eb = 1'b1;
      tick();
      repeat (j - 1) tick();
      dacc = 1'b1;
      tick();
      check("R8 lost after delay", {7'd0, lost}, {7'd0, el});
      check("R4 status bit2 tracks lost", {7'd0, st[2]}, {7'd0, el});
    end

    mfm = 1'b1; half = 1'b0;
    do_load(2'd2);
    ewp = 1'b1; edel = 1'b1;
    tick();
    check("R9 write class bit6 set bit5 zero", {6'd0, st[6], st[5]}, 8'b10);
    ed = 1'b1;
    tick();
    check("R3 R4 write class final status", st, 8'b0100_0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule